// File: doc/BRIEF.md
# Pin Drive Register Bank with Atomic Bit Aliases

This block holds the drive level and the drive enable for seven general-purpose pins behind a small word-addressed register bus. Software can reach each of the two state registers in three ways: a plain location that replaces every bit at once, a location that raises only the bits written as one, and a location that lowers only the bits written as one. With the raising and lowering locations, a driver can change one pin without reading the register first, so two agents that share the bank cannot overwrite each other's bits.

A read-only location returns the present level on the pins. The two state vectors go straight out as `pin_out` and `pin_oe` for the pad ring to use. Read data is combinational from the address. Writes take effect on the next rising clock edge. The reset input is asserted asynchronously and is released through a two-stage synchronizer, so state stays cleared for two clock edges after `rst_n` rises.

Top module: `gpio_out_bank`

## Requirements
- R1: While reset is held, and after it is released, `pin_out` and `pin_oe` are all zeros. A read of offset 0x04 after release returns 0.
- R2: A write to offset 0x04 (drive level) replaces all seven `pin_out` bits with write data bits [6:0] on the next clock edge. A read of 0x04 returns the stored value.
- R3: A write to offset 0x08 forces to 1 each `pin_out` bit whose write data bit is 1. All other bits keep their value.
- R4: A write to offset 0x0C forces to 0 each `pin_out` bit whose write data bit is 1. All other bits keep their value.
- R5: A write to offset 0x10 (drive enable) replaces all seven `pin_oe` bits with write data bits [6:0]. A read of 0x10 returns the stored value.
- R6: A write to offset 0x14 sets, and a write to offset 0x18 clears, the `pin_oe` bits whose write data bit is 1. The other enable bits keep their value.
- R7: Reads of the four alias offsets 0x08, 0x0C, 0x14 and 0x18 return 0.
- R8: A read of offset 0x1C returns `pin_in` zero-extended, in the same cycle that `pin_in` changes. A write to 0x1C changes no state.
- R9: Write data bits [31:7] have no effect on any register, and read data bits [31:7] are always 0.
- R10: Writes to any other address (unmapped or not word-aligned, for example 0x00, 0x05 or 0x20) change no state, and reads of those addresses return 0.
- R11: In any cycle with no write, `pin_out` and `pin_oe` hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 7 | Present pin levels |
| pin_out | output | 7 | Drive level per pin |
| pin_oe | output | 7 | Drive enable per pin |

## Verification
On every cycle the assertions check the effect of each write location on the state vectors one clock later, that the state holds when there is no write, that alias reads return zero, that the input location reflects `pin_in`, and that the upper read bits are clear. Some cases can only be shown by the bench's scenarios. These include the exact value sequence over a chain of mixed set, clear and replace writes, the reset clear asserted in the middle of a run, writes to unmapped and misaligned addresses, and set or clear writes repeated on bits that already hold the target value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned PIN_N     = 7;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned WORD_B    = 4;
  localparam int unsigned REG_N     = 2;   // drive level, drive enable
  localparam int unsigned ALIAS_N   = 3;   // plain, set, clear
  localparam int unsigned FIRST_OFS = 4;
  localparam int unsigned REG_STRIDE = ALIAS_N * WORD_B;
  localparam int unsigned PIN_OFS   = FIRST_OFS + REG_N * REG_STRIDE;
  localparam int unsigned SYNC_N    = 2;

  // Per-register write strobes produced by the decoder
  typedef struct packed {
    logic plain;
    logic set;
    logic clr;
  } reg_hit_t;
endpackage

// File: rtl/gpio_bank_rst_sync.sv
module gpio_bank_rst_sync #(
  parameter int unsigned STAGES = gpio_bank_pkg::SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NREG = REG_N
) (
  input  logic [AW-1:0]  addr,
  output reg_hit_t       hit [NREG],
  output logic           hit_pin
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int unsigned BASE = FIRST_OFS + g * REG_STRIDE;
    assign hit[g].plain = (addr == AW'(BASE));
    assign hit[g].set   = (addr == AW'(BASE + WORD_B));
    assign hit[g].clr   = (addr == AW'(BASE + 2 * WORD_B));
  end

  assign hit_pin = (addr == AW'(FIRST_OFS + NREG * REG_STRIDE));
endmodule

// File: rtl/gpio_bank_bitreg.sv
module gpio_bank_bitreg #(
  parameter int unsigned W = gpio_bank_pkg::PIN_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         ld;

  always_comb begin
    q_d = q;
    if (wr_en)  q_d = wdata;
    if (set_en) q_d = q | wdata;
    if (clr_en) q_d = q & ~wdata;
  end

  assign ld = wr_en | set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= q_d;
  end
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN = PIN_N,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned AW   = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  localparam int unsigned NREG = REG_N;

  logic                      rst_sync_n;
  reg_hit_t                  hit [NREG];
  logic                      hit_pin;
  logic [NREG-1:0][NPIN-1:0] state;
  logic [NPIN-1:0]           wdata_lo;
  logic                      unused_wdata_hi;
  logic [DW-1:0]             rdata_d;

  gpio_bank_rst_sync #(.STAGES(SYNC_N)) rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  gpio_bank_decode #(.AW(AW), .NREG(NREG)) decode_i (
    .addr   (bus_addr),
    .hit    (hit),
    .hit_pin(hit_pin)
  );

  assign wdata_lo        = bus_wdata[NPIN-1:0];
  assign unused_wdata_hi = ^bus_wdata[DW-1:NPIN];

  for (genvar g = 0; g < NREG; g++) begin : g_state
    gpio_bank_bitreg #(.W(NPIN)) reg_i (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .wr_en (bus_wr & hit[g].plain),
      .set_en(bus_wr & hit[g].set),
      .clr_en(bus_wr & hit[g].clr),
      .wdata (wdata_lo),
      .q     (state[g])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i].plain) rdata_d[NPIN-1:0] = state[i];
    end
    if (hit_pin) rdata_d[NPIN-1:0] = pin_in;
  end

  assign bus_rdata = rdata_d;
  assign pin_out   = state[0];
  assign pin_oe    = state[1];
endmodule

// File: rtl/gpio_out_bank_chk.sv
module gpio_out_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN = PIN_N,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned AW   = ADDR_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NPIN-1:0] pin_in,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe
);
  localparam logic [AW-1:0] A_DOUT = AW'(FIRST_OFS);
  localparam logic [AW-1:0] A_DSET = AW'(FIRST_OFS + WORD_B);
  localparam logic [AW-1:0] A_DCLR = AW'(FIRST_OFS + 2 * WORD_B);
  localparam logic [AW-1:0] A_EN   = AW'(FIRST_OFS + REG_STRIDE);
  localparam logic [AW-1:0] A_ESET = AW'(FIRST_OFS + REG_STRIDE + WORD_B);
  localparam logic [AW-1:0] A_ECLR = AW'(FIRST_OFS + REG_STRIDE + 2 * WORD_B);
  localparam logic [AW-1:0] A_PIN  = AW'(PIN_OFS);

  AST_DOUT_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_DOUT |=> pin_out == $past(bus_wdata[NPIN-1:0])); // R2
  AST_DOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_DSET |=>
      pin_out == ($past(pin_out) | $past(bus_wdata[NPIN-1:0]))); // R3
  AST_DOUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_DCLR |=>
      pin_out == ($past(pin_out) & ~$past(bus_wdata[NPIN-1:0]))); // R4
  AST_OE_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_EN |=> pin_oe == $past(bus_wdata[NPIN-1:0])); // R5
  AST_OE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_ESET |=>
      pin_oe == ($past(pin_oe) | $past(bus_wdata[NPIN-1:0]))); // R6
  AST_OE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_ECLR |=>
      pin_oe == ($past(pin_oe) & ~$past(bus_wdata[NPIN-1:0]))); // R6
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DSET || bus_addr == A_DCLR || bus_addr == A_ESET ||
     bus_addr == A_ECLR) |-> bus_rdata == '0); // R7
  AST_PIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == A_PIN |-> bus_rdata == DW'(pin_in)); // R8
  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NPIN] == '0); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out) && $stable(pin_oe)); // R11
endmodule

bind gpio_out_bank gpio_out_bank_chk #(.NPIN(NPIN), .DW(DW), .AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_in   (pin_in),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe)
);

// File: tb/gpio_out_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_out_bank_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [6:0]  pin_in;
  logic [6:0]  pin_out;
  logic [6:0]  pin_oe;

  int checks = 0;
  int errors = 0;

  gpio_out_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [6:0]  eout;
    logic [6:0]  eoe;
    logic [7:0]  raddr;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 32'hFFFF_FF5A, 7'h5A, 7'h00, 8'h04, 32'h0000_005A}, // R2 R9
    '{8'h08, 32'h0000_0005, 7'h5F, 7'h00, 8'h08, 32'h0000_0000}, // R3 R7
    '{8'h0C, 32'h0000_000A, 7'h55, 7'h00, 8'h04, 32'h0000_0055}, // R4
    '{8'h10, 32'h0000_000F, 7'h55, 7'h0F, 8'h10, 32'h0000_000F}, // R5
    '{8'h14, 32'h0000_0070, 7'h55, 7'h7F, 8'h14, 32'h0000_0000}, // R6 R7
    '{8'h18, 32'h0000_0003, 7'h55, 7'h7C, 8'h18, 32'h0000_0000}, // R6 R7
    '{8'h1C, 32'h0000_007F, 7'h55, 7'h7C, 8'h1C, 32'h0000_002A}, // R8
    '{8'h00, 32'hFFFF_FFFF, 7'h55, 7'h7C, 8'h00, 32'h0000_0000}, // R10
    '{8'h20, 32'hFFFF_FFFF, 7'h55, 7'h7C, 8'h20, 32'h0000_0000}, // R10
    '{8'h05, 32'h0000_0000, 7'h55, 7'h7C, 8'h0C, 32'h0000_0000}, // R10
    '{8'h08, 32'hFFFF_FF80, 7'h55, 7'h7C, 8'h04, 32'h0000_0055}, // R9
    '{8'h04, 32'h0000_0000, 7'h00, 7'h7C, 8'h10, 32'h0000_007C}  // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] hold_out;
    logic [6:0] hold_oe;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pin_in = 7'h2A;
    repeat (3) @(negedge clk);
    chk("R1 reset out", 32'(pin_out), 32'h0);
    chk("R1 reset oe", 32'(pin_oe), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R1 read after release", 8'h04, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i].waddr, VECS[i].wdata);
      #1;
      chk($sformatf("vec%0d out", i), 32'(pin_out), 32'(VECS[i].eout));
      chk($sformatf("vec%0d oe", i), 32'(pin_oe), 32'(VECS[i].eoe));
      read_chk($sformatf("vec%0d read", i), VECS[i].raddr, VECS[i].erd);
    end

    // R11: idle cycles leave the state alone
    hold_out = pin_out;
    hold_oe  = pin_oe;
    repeat (5) @(negedge clk);
    chk("R11 idle out", 32'(pin_out), 32'(hold_out));
    chk("R11 idle oe", 32'(pin_oe), 32'(hold_oe));

    // R8: input read follows pin_in within the same cycle
    pin_in = 7'h13;
    read_chk("R8 live input", 8'h1C, 32'h13);
    pin_in = 7'h7F;
    read_chk("R8 live input all ones", 8'h1C, 32'h7F);

    // R3/R4: repeated set and clear on bits that already hold the target value
    bus_write(8'h08, 32'h41);
    bus_write(8'h08, 32'h41);
    #1 chk("R3 repeated set", 32'(pin_out), 32'h41);
    bus_write(8'h0C, 32'h40);
    bus_write(8'h0C, 32'h40);
    #1 chk("R4 repeated clear", 32'(pin_out), 32'h01);
    read_chk("R4 read back", 8'h04, 32'h01);

    // R1: reset in the middle of a run clears at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run out", 32'(pin_out), 32'h0);
    chk("R1 mid-run oe", 32'(pin_oe), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R1 enable read after reset", 8'h10, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule